// File: doc/BRIEF.md
# Reliable Link Packet Transmitter

This block drives one point-to-point serial link of a torus node. It takes a stream of 32-bit payload words from an injection queue and cuts it into fixed-size packets. Each packet goes to the link's word-wide transmit port as a header word, 32 payload words (128 bytes) and a CRC word. The header carries the packet's virtual-channel tag and a short sequence number.

Every packet that has been sent stays in a four-slot replay store until the far end acknowledges it. The far end reports back on a feedback channel. Each token on that channel is either an acknowledgment or a negative acknowledgment, and it names a sequence number. An acknowledgment frees the named packet and every older one. A negative acknowledgment winds the transmit position back to the named packet. Once the packet on the wire has finished, that packet and all later ones are sent again in order, and then new traffic continues. Because replay is always go-back and in order, the receiver sees packets in exactly the order they were injected. When all four slots hold unacknowledged packets, the block stops taking payload words.

Top module: `rlink_tx`

## Requirements
- R1: Each packet is sent as 34 accepted words in this order: one header word, then the 32 payload words in the order they were injected, then one CRC word. `tx_first` is high only while the header word is offered.
- R2: Header word layout:
  - bits [31:24] hold 0xC3;
  - bits [10:8] hold the virtual channel sampled with the packet's first payload word;
  - bits [1:0] hold the sequence number, which is the packet's injection count modulo 4;
  - all other bits are zero.
- R3: The CRC word is a reflected CRC-32 over the header word and then the payload words.
  - The polynomial is 0xEDB88320, the initial value is all ones, and the final value is inverted.
  - Each word is consumed starting with its low byte, and each byte least-significant bit first.
- R4: While `tx_valid` is high and `tx_ready` is low, the next cycle keeps `tx_valid` high with `tx_data` and `tx_first` unchanged.
- R5: The replay store holds 4 unacknowledged packets. While all 4 slots are occupied, `in_ready` is low. `in_ready` rises again once an acknowledgment frees a slot.
- R6: An acknowledgment (`fb_nack`=0) naming sequence n frees packet n and every older unacknowledged packet.
- R7: A negative acknowledgment (`fb_nack`=1) naming sequence n takes effect once the packet in progress has finished. Packet n and every later sent packet are then resent in order, before any packet that was never sent.
- R8: A negative acknowledgment frees no slot: with the store full, `in_ready` stays low after it.
- R9: A feedback token whose sequence number does not name a packet that has been sent and is still unacknowledged is ignored.
- R10: After reset, `tx_valid` is low and `in_ready` is high.
- R11: When every stored packet has been sent and no replay is pending, `tx_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload word offered by the injection queue |
| in_ready | output | 1 | Payload word is taken this cycle |
| in_data | input | 32 | Payload word |
| in_vc | input | 3 | Virtual channel, sampled with the first word of each packet |
| fb_valid | input | 1 | Feedback token present |
| fb_nack | input | 1 | 1 = negative acknowledgment, 0 = acknowledgment |
| fb_seq | input | 2 | Sequence number the token names |
| tx_valid | output | 1 | Word offered to the link |
| tx_ready | input | 1 | Link takes the offered word |
| tx_data | output | 32 | Link word |
| tx_first | output | 1 | Offered word is a packet header |

## Verification
First, single packets are acknowledged one at a time. Then packets run back-to-back under pseudo-random link back-pressure, which shows whether framing, CRC and data hold steady across stalls. A cumulative acknowledgment followed by a burst of exactly four packets tells a correct release of several slots apart from a release of only one. Filling the store and issuing a negative acknowledgment separates a replay that frees slots from one that keeps them. Stale or future sequence numbers show whether out-of-window feedback is ignored. A negative acknowledgment sent in the middle of a packet separates a rewind applied at the packet boundary from one that cuts a packet short or skips ahead.

// File: rtl/rlink_pkg.sv
package rlink_pkg;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;
    localparam logic [7:0]  HDR_MARK = 8'hC3;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_HDR,
        FR_PAY,
        FR_CRC
    } fr_state_e;

    // one word of reflected CRC-32, bit 0 of the word first
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 32; i++) begin
            if (r[0] ^ w[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rlink_replay_store.sv
module rlink_replay_store #(
    parameter int DEPTH     = 4,
    parameter int PAY_WORDS = 32,
    parameter int VC_W      = 3,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int WI_W     = $clog2(PAY_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    input  logic [VC_W-1:0]  in_vc,
    input  logic             fill_ok,
    input  logic [IDX_W-1:0] wr_slot,
    output logic             in_ready,
    output logic             pkt_done,
    input  logic [IDX_W-1:0] rd_slot,
    input  logic [WI_W-1:0]  rd_word,
    output logic [31:0]      rd_data,
    output logic [VC_W-1:0]  rd_vc
);

    localparam logic [WI_W-1:0] LAST_W = WI_W'(PAY_WORDS - 1);

    typedef struct packed {
        logic [WI_W-1:0] widx;
    } st_t;

    st_t s_d, s_q;
    logic acc;

    logic [31:0]     mem_q [DEPTH][PAY_WORDS];
    logic [VC_W-1:0] vc_q  [DEPTH];

    assign in_ready = fill_ok;
    assign acc      = in_valid && fill_ok;
    assign pkt_done = acc && (s_q.widx == LAST_W);
    assign rd_data  = mem_q[rd_slot][rd_word];
    assign rd_vc    = vc_q[rd_slot];

    always_comb begin
        s_d = s_q;
        if (acc) begin
            if (s_q.widx == LAST_W) s_d.widx = '0;
            else                    s_d.widx = s_q.widx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (acc) begin
            mem_q[wr_slot][s_q.widx] <= in_data;
            if (s_q.widx == '0) vc_q[wr_slot] <= in_vc;
        end
    end

endmodule

// File: rtl/rlink_window.sv
module rlink_window #(
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_done,
    input  logic             fb_valid,
    input  logic             fb_nack,
    input  logic [IDX_W-1:0] fb_seq,
    input  logic             take,
    input  logic             busy,
    input  logic [PTR_W-1:0] cur_ptr,
    output logic [IDX_W-1:0] wr_slot,
    output logic             fill_ok,
    output logic             pend,
    output logic [PTR_W-1:0] send_ptr,
    output logic [PTR_W-1:0] occ
);

    localparam logic [PTR_W-1:0] FULL_OCC = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] ONE      = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [PTR_W-1:0] send;
        logic [PTR_W-1:0] hw;
        logic [PTR_W-1:0] rw_tgt;
        logic             rw_pend;
    } st_t;

    st_t s_d, s_q;

    logic [IDX_W-1:0] k;
    logic [PTR_W-1:0] n_full, n_next, d_n, d_hw, d_next, d_send, d_rw;
    logic             fb_hit;

    assign occ      = s_q.head - s_q.tail;
    assign wr_slot  = s_q.head[IDX_W-1:0];
    assign send_ptr = s_q.send;
    assign pend     = (s_q.send != s_q.head) && !s_q.rw_pend;
    // a slot freed under a packet still on the wire is not refilled yet
    assign fill_ok  = (occ != FULL_OCC) &&
                      !(busy && (s_q.head[IDX_W-1:0] == cur_ptr[IDX_W-1:0]) &&
                        (s_q.head != cur_ptr));

    always_comb begin
        s_d    = s_q;
        k      = fb_seq - s_q.tail[IDX_W-1:0];
        n_full = s_q.tail + {{(PTR_W-IDX_W){1'b0}}, k};
        n_next = n_full + ONE;
        d_n    = n_full - s_q.tail;
        d_hw   = s_q.hw - s_q.tail;
        d_next = d_n + ONE;
        fb_hit = fb_valid && (d_n < d_hw);

        if (!busy && s_q.rw_pend) begin
            s_d.send    = s_q.rw_tgt;
            s_d.rw_pend = 1'b0;
        end else if (take) begin
            s_d.send = s_q.send + ONE;
            if (s_q.send == s_q.hw) s_d.hw = s_q.hw + ONE;
        end

        d_send = s_d.send - s_q.tail;
        d_rw   = s_d.rw_tgt - s_q.tail;

        if (fb_hit && !fb_nack) begin
            s_d.tail = n_next;
            if (d_send < d_next) s_d.send = n_next;
            if (s_d.rw_pend && (d_rw < d_next)) s_d.rw_tgt = n_next;
        end
        if (fb_hit && fb_nack) begin
            s_d.rw_pend = 1'b1;
            s_d.rw_tgt  = n_full;
        end

        if (pkt_done) s_d.head = s_q.head + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/rlink_framer.sv
module rlink_framer
    import rlink_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int PAY_WORDS = 32,
    parameter int VC_W      = 3,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int PTR_W    = IDX_W + 1,
    localparam int WI_W     = $clog2(PAY_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    input  logic [PTR_W-1:0] send_ptr,
    input  logic [31:0]      rd_data,
    input  logic [VC_W-1:0]  rd_vc,
    input  logic             tx_ready,
    output logic             take,
    output logic             busy,
    output logic [PTR_W-1:0] cur_ptr,
    output logic [IDX_W-1:0] rd_slot,
    output logic [WI_W-1:0]  rd_word,
    output logic             tx_valid,
    output logic [31:0]      tx_data,
    output logic             tx_first
);

    localparam logic [WI_W-1:0] LAST_W = WI_W'(PAY_WORDS - 1);

    typedef struct packed {
        fr_state_e        state;
        logic [PTR_W-1:0] cur;
        logic [WI_W-1:0]  widx;
        logic [31:0]      crc;
    } st_t;

    st_t s_d, s_q;
    logic [31:0] hdr;

    assign take     = (s_q.state == FR_IDLE) && pend;
    assign busy     = (s_q.state != FR_IDLE);
    assign cur_ptr  = s_q.cur;
    assign rd_slot  = s_q.cur[IDX_W-1:0];
    assign rd_word  = s_q.widx;
    assign tx_valid = busy;
    assign tx_first = (s_q.state == FR_HDR);

    always_comb begin
        hdr                = '0;
        hdr[31:24]         = HDR_MARK;
        hdr[8 +: VC_W]     = rd_vc;
        hdr[IDX_W-1:0]     = s_q.cur[IDX_W-1:0];
    end

    always_comb begin
        case (s_q.state)
            FR_HDR:  tx_data = hdr;
            FR_PAY:  tx_data = rd_data;
            FR_CRC:  tx_data = ~s_q.crc;
            default: tx_data = '0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            FR_IDLE: begin
                if (take) begin
                    s_d.state = FR_HDR;
                    s_d.cur   = send_ptr;
                    s_d.widx  = '0;
                    s_d.crc   = CRC_INIT;
                end
            end
            FR_HDR: begin
                if (tx_ready) begin
                    s_d.crc   = crc_step(s_q.crc, hdr);
                    s_d.state = FR_PAY;
                end
            end
            FR_PAY: begin
                if (tx_ready) begin
                    s_d.crc = crc_step(s_q.crc, rd_data);
                    if (s_q.widx == LAST_W) s_d.state = FR_CRC;
                    else                    s_d.widx  = s_q.widx + 1'b1;
                end
            end
            default: begin
                if (tx_ready) s_d.state = FR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= FR_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/rlink_tx.sv
module rlink_tx #(
    parameter int DEPTH     = 4,
    parameter int PAY_WORDS = 32,
    parameter int VC_W      = 3,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int PTR_W    = IDX_W + 1,
    localparam int WI_W     = $clog2(PAY_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_data,
    input  logic [VC_W-1:0]  in_vc,
    input  logic             fb_valid,
    input  logic             fb_nack,
    input  logic [IDX_W-1:0] fb_seq,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [31:0]      tx_data,
    output logic             tx_first
);

    logic             fill_ok, pkt_done, pend, take, busy;
    logic [IDX_W-1:0] wr_slot, rd_slot;
    logic [WI_W-1:0]  rd_word;
    logic [31:0]      rd_data;
    logic [VC_W-1:0]  rd_vc;
    logic [PTR_W-1:0] send_ptr, cur_ptr, occ;

    rlink_replay_store #(.DEPTH(DEPTH), .PAY_WORDS(PAY_WORDS), .VC_W(VC_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_vc    (in_vc),
        .fill_ok  (fill_ok),
        .wr_slot  (wr_slot),
        .in_ready (in_ready),
        .pkt_done (pkt_done),
        .rd_slot  (rd_slot),
        .rd_word  (rd_word),
        .rd_data  (rd_data),
        .rd_vc    (rd_vc)
    );

    rlink_window #(.DEPTH(DEPTH)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_done (pkt_done),
        .fb_valid (fb_valid),
        .fb_nack  (fb_nack),
        .fb_seq   (fb_seq),
        .take     (take),
        .busy     (busy),
        .cur_ptr  (cur_ptr),
        .wr_slot  (wr_slot),
        .fill_ok  (fill_ok),
        .pend     (pend),
        .send_ptr (send_ptr),
        .occ      (occ)
    );

    rlink_framer #(.DEPTH(DEPTH), .PAY_WORDS(PAY_WORDS), .VC_W(VC_W)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend),
        .send_ptr (send_ptr),
        .rd_data  (rd_data),
        .rd_vc    (rd_vc),
        .tx_ready (tx_ready),
        .take     (take),
        .busy     (busy),
        .cur_ptr  (cur_ptr),
        .rd_slot  (rd_slot),
        .rd_word  (rd_word),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_first (tx_first)
    );

endmodule

// File: rtl/rlink_tx_chk.sv
module rlink_tx_chk #(
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [31:0]      tx_data,
    input logic             tx_first,
    input logic [PTR_W-1:0] occ
);

    localparam logic [PTR_W-1:0] FULL_OCC = PTR_W'(DEPTH);

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_first)));

    // R5
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_OCC);

    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == FULL_OCC) |-> !in_ready);

    // R1
    first_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_first |-> tx_valid);

    // R1
    single_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_first && tx_ready) |=> !tx_first);

endmodule

bind rlink_tx rlink_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_first (tx_first),
    .occ      (occ)
);

// File: tb/sim_rlink_tx.sv
`timescale 1ns/1ps
module sim_rlink_tx;

    localparam int PW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [2:0]  in_vc = '0;
    logic        fb_valid = 1'b0;
    logic        fb_nack = 1'b0;
    logic [1:0]  fb_seq = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [31:0] tx_data;
    logic        tx_first;

    always #10 clk = ~clk;

    rlink_tx u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_vc(in_vc),
        .fb_valid(fb_valid), .fb_nack(fb_nack), .fb_seq(fb_seq),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_first(tx_first)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state (packet indices, not pointers)
    logic [31:0] pay [64][PW];
    logic [2:0]  pvc [64];
    int m_head = 0, m_iw = 0, m_tail = 0, m_send = 0, m_hw = 0;
    int m_cur = 0, m_w = 0, m_rw_tgt = 0, hdr_cnt = 0;
    bit m_inflight = 0, m_rw_pend = 0;
    bit prev_stall = 0;
    logic [31:0] prev_data;
    logic        prev_first;
    bit rand_rdy = 0;
    bit inj_busy = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int idx);
        logic [31:0] c;
        logic [31:0] w;
        c = 32'hFFFFFFFF;
        for (int j = 0; j <= PW; j++) begin
            w = (j == 0) ? ref_hdr(idx) : pay[idx][j-1];
            for (int b = 0; b < 4; b++) begin
                c = c ^ {24'd0, w[8*b +: 8]};
                for (int t = 0; t < 8; t++)
                    c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    function automatic logic [31:0] ref_hdr(input int idx);
        return {8'hC3, 13'd0, pvc[idx], 6'd0, 2'(idx % 4)};
    endfunction

    function automatic logic [31:0] gen_word(input int idx, input int i);
        return (32'(idx) * 32'h9E3779B1) ^ (32'(i) * 32'h01000193) ^ 32'h5A5A0F0F;
    endfunction

    // monitor and model, evaluated between edges
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [31:0] exp;
            string tag;
            int k, nf;
            if (prev_stall)
                check(tx_valid && tx_data == prev_data && tx_first == prev_first,
                      "R4 hold", {tx_valid, tx_data[30:0]}, {1'b1, prev_data[30:0]});
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            prev_first = tx_first;

            if (tx_valid && tx_ready) begin
                if (!m_inflight) begin
                    check(m_send < m_head, "R7 unexpected packet", 32'(m_send), 32'(m_head));
                    m_cur = m_send;
                    m_send++;
                    if (m_cur == m_hw) m_hw++;
                    m_inflight = 1;
                    m_w = 0;
                    hdr_cnt++;
                end
                if (m_w == 0) begin exp = ref_hdr(m_cur); tag = "R2 header"; end
                else if (m_w <= PW) begin exp = pay[m_cur][m_w-1]; tag = "R1 payload"; end
                else begin exp = ref_crc(m_cur); tag = "R3 crc"; end
                check(tx_data == exp, tag, tx_data, exp);
                check(tx_first == (m_w == 0), "R1 first flag", 32'(tx_first), 32'(m_w == 0));
                m_w++;
                if (m_w == PW + 2) begin
                    m_inflight = 0;
                    if (m_rw_pend) begin m_send = m_rw_tgt; m_rw_pend = 0; end
                end
            end

            if (fb_valid) begin
                k  = (int'(fb_seq) - m_tail) & 3;
                nf = m_tail + k;
                if (nf < m_hw) begin
                    if (!fb_nack) begin
                        m_tail = nf + 1;
                        if (m_send < m_tail) m_send = m_tail;
                        if (m_rw_pend && m_rw_tgt < m_tail) m_rw_tgt = m_tail;
                    end else begin
                        m_rw_pend = 1;
                        m_rw_tgt  = nf;
                        if (!m_inflight) begin m_send = m_rw_tgt; m_rw_pend = 0; end
                    end
                end
            end

            if (in_valid && in_ready) begin
                pay[m_head][m_iw] = in_data;
                if (m_iw == 0) pvc[m_head] = in_vc;
                m_iw++;
                if (m_iw == PW) begin m_iw = 0; m_head++; end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rand_rdy) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tx_ready = lfsr[0] | lfsr[3];
            end
        end
    end

    task automatic inject_pkt(input int idx, input logic [2:0] vc, input string tag);
        bit ok;
        int waitc;
        inj_busy = 1;
        for (int i = 0; i < PW; i++) begin
            in_valid = 1'b1;
            in_data  = gen_word(idx, i);
            in_vc    = vc;
            waitc    = 0;
            do begin
                @(negedge clk);
                ok = in_ready;
                @(posedge clk);
                #1;
                waitc++;
            end while (!ok && waitc < 3000);
            if (!ok) begin
                check(0, tag, 32'(i), 32'(PW));
                i = PW;
            end
        end
        in_valid = 1'b0;
        inj_busy = 0;
    endtask

    task automatic send_fb(input bit nack, input logic [1:0] seq);
        fb_valid = 1'b1;
        fb_nack  = nack;
        fb_seq   = seq;
        @(posedge clk);
        #1;
        fb_valid = 1'b0;
    endtask

    task automatic quiesce(input bit need_inj);
        int t;
        t = 0;
        while ((m_inflight || m_send != m_head || m_rw_pend || (need_inj && inj_busy)) && t < 20000) begin
            @(posedge clk);
            #1;
            t++;
        end
        repeat (4) @(posedge clk);
        #1;
        @(negedge clk);
        check(!tx_valid, "R11 idle", 32'(tx_valid), 32'd0);
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int base;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!tx_valid, "R10 tx_valid", 32'(tx_valid), 32'd0);
        check(in_ready, "R10 in_ready", 32'(in_ready), 32'd1);
        @(posedge clk);
        #1;

        // single packet, acknowledged
        inject_pkt(0, 3'd1, "R1 inject");
        quiesce(1);
        send_fb(0, 2'd0);

        // two packets under back-pressure, cumulative acknowledgment
        rand_rdy = 1;
        inject_pkt(1, 3'd5, "R4 inject");
        inject_pkt(2, 3'd7, "R4 inject");
        quiesce(1);
        rand_rdy = 0;
        tx_ready = 1'b1;
        send_fb(0, 2'd2);

        // R6: four more must fit only if both were freed
        inject_pkt(3, 3'd2, "R6 release");
        inject_pkt(4, 3'd4, "R6 release");
        inject_pkt(5, 3'd6, "R6 release");
        inject_pkt(6, 3'd3, "R6 release");
        quiesce(1);

        // R5: store full, fifth packet stalls
        fork inject_pkt(7, 3'd0, "R5 resume"); join_none
        repeat (20) @(posedge clk);
        #1;
        @(negedge clk);
        check(!in_ready, "R5 stall", 32'(in_ready), 32'd0);
        @(posedge clk);
        #1;

        // R8: negative acknowledgment of seq 0 (packet 4) frees nothing
        base = hdr_cnt;
        send_fb(1, 2'd0);
        quiesce(0);
        check(hdr_cnt - base == 3, "R7 replay count", 32'(hdr_cnt - base), 32'd3);
        @(negedge clk);
        check(!in_ready, "R8 still full", 32'(in_ready), 32'd0);
        @(posedge clk);
        #1;

        // R5 resume after acknowledgment of packet 3 (seq 3)
        send_fb(0, 2'd3);
        quiesce(1);
        check(m_head == 8, "R5 resume", 32'(m_head), 32'd8);
        send_fb(0, 2'd2);

        // R9: only packet 7 (seq 3) outstanding; seq 0 and 1 are outside
        send_fb(0, 2'd0);
        send_fb(1, 2'd1);
        repeat (10) @(posedge clk);
        #1;
        @(negedge clk);
        check(!tx_valid, "R9 ignored nack", 32'(tx_valid), 32'd0);
        @(posedge clk);
        #1;
        base = hdr_cnt;
        send_fb(1, 2'd3);
        quiesce(0);
        check(hdr_cnt - base == 1, "R9 window kept", 32'(hdr_cnt - base), 32'd1);
        send_fb(0, 2'd3);

        // R7: mid-packet negative acknowledgment
        tx_ready = 1'b0;
        inject_pkt(8, 3'd1, "R7 inject");
        inject_pkt(9, 3'd2, "R7 inject");
        inject_pkt(10, 3'd3, "R7 inject");
        base = hdr_cnt;
        tx_ready = 1'b1;
        wait (m_inflight && m_cur == 9 && m_w == 10);
        @(posedge clk);
        #1;
        send_fb(1, 2'd0);
        quiesce(1);
        check(hdr_cnt - base == 5, "R7 go-back count", 32'(hdr_cnt - base), 32'd5);
        send_fb(0, 2'd2);
        repeat (5) @(posedge clk);
        #1;
        @(negedge clk);
        check(in_ready, "R6 all freed", 32'(in_ready), 32'd1);
        finish_run();
    end

endmodule